// File: doc/BRIEF.md
# Programmable Time-Constant Baud Generator

The block turns a fixed reference clock into the bit-rate timing that a serial communications controller needs. Software loads a 16-bit time constant one byte at a time. A down-counter runs for time_constant + 2 reference cycles in each half of its output period, and it toggles a square-wave generator clock at the end of each half. The full generator period is therefore 2 x (TC + 2) reference cycles. This matches the relation TC = f_ref / (2 x baud x mode) - 2. With the nominal 9.8304 MHz reference and mode x16, TC = 14 gives 19200 baud.

A second divider counts rising edges of the generator clock. It uses the selected clock-mode multiplier (x1, x16, x32 or x64), which is the same multiplier the formula uses. After the selected number of generator periods it emits a one-cycle strobe. The enable input holds the generator idle and low. A new time constant is picked up only at the next reload of the counter, so the half-period in progress is never cut short.

Top module: `baud_gen_top`

## Requirements
- R1: After reset, gen_clk_o and bit_stb_o are 0 and the counter is loaded from the reset time constant (TC_RESET, 0 by default). With en_i high, the first rising edge of gen_clk_o therefore appears TC_RESET + 2 clock edges after reset is released.
- R2: While en_i is high, each high phase and each low phase of gen_clk_o lasts TC + 2 clock cycles. After en_i rises, the first rising edge of gen_clk_o comes TC + 2 clock edges later.
- R3: The time constant is 16 bits. A write with tc_lo_we_i loads bits 7:0 from tc_lo_i, and a write with tc_hi_we_i loads bits 15:8 from tc_hi_i. The other byte is left unchanged. Each write takes effect at the next clock edge.
- R4: A time constant written during a half-period does not change the length of that half-period. It applies from the next reload onward.
- R5: While en_i is low, gen_clk_o and bit_stb_o stay 0. The counter is held at its reload value and the mode divider is cleared, so after enable the first strobe comes on the mult-th rising edge.
- R6: mode_i selects the multiplier: 00 gives x1, 01 gives x16, 10 gives x32 and 11 gives x64. bit_stb_o pulses once every mult generator periods, that is every mult x 2 x (TC + 2) clock cycles.
- R7: bit_stb_o is one clock cycle wide. It is asserted in the cycle after the rising edge of gen_clk_o that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Generator enable |
| tc_lo_i | input | 8 | Time-constant low byte |
| tc_lo_we_i | input | 1 | Low-byte write strobe |
| tc_hi_i | input | 8 | Time-constant high byte |
| tc_hi_we_i | input | 1 | High-byte write strobe |
| mode_i | input | 2 | Clock-mode select (x1/x16/x32/x64) |
| gen_clk_o | output | 1 | Generator square wave |
| bit_stb_o | output | 1 | One-cycle bit-rate strobe |

## Verification
The hardest case to reach from the ports is a time-constant write that lands in the middle of a half-period. Its correct effect shows only in the phase after the current one. The bench waits for a sampled rising edge of gen_clk_o and writes a much smaller constant right after it. It then measures the current high phase, which must keep the old length, and the following low and high phases, which must take the new length. Clearing of the divider on disable is also hidden. It is exposed by timing the first strobe after a fresh enable in x16 mode against the exact count of 16 rising edges.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    MODE_X1  = 2'b00,
    MODE_X16 = 2'b01,
    MODE_X32 = 2'b10,
    MODE_X64 = 2'b11
  } clk_mode_e;

  localparam int unsigned MAX_MULT = 64;
  localparam int unsigned DIV_W    = $clog2(MAX_MULT);

  function automatic logic [DIV_W-1:0] mode_last(input clk_mode_e m);
    case (m)
      MODE_X1:  mode_last = DIV_W'(0);
      MODE_X16: mode_last = DIV_W'(15);
      MODE_X32: mode_last = DIV_W'(31);
      default:  mode_last = DIV_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/baud_tc_reg.sv
module baud_tc_reg #(
  parameter int unsigned TC_W     = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter logic [TC_W-1:0] TC_RESET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic              lo_we_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              hi_we_i,
  output logic [TC_W-1:0]   tc_o
);
  localparam int unsigned HI_W = TC_W - BYTE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_o <= TC_RESET;
    end else begin
      if (lo_we_i) tc_o[BYTE_W-1:0]    <= lo_i;
      if (hi_we_i) tc_o[TC_W-1:BYTE_W] <= hi_i[HI_W-1:0];
    end
  end

  p_lo_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_we_i |=> tc_o[BYTE_W-1:0] == $past(lo_i));
  p_hi_keep_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !lo_we_i) |=> $stable(tc_o[BYTE_W-1:0]));
endmodule

// File: rtl/baud_half_ctr.sv
module baud_half_ctr #(
  parameter int unsigned TC_W = 16,
  parameter logic [TC_W-1:0] TC_RESET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            gen_clk_o,
  output logic            rise_o
);
  localparam int unsigned CNT_W = TC_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             expire;

  // half-period spans reload..0 = TC + 2 cycles
  assign reload = {1'b0, tc_i} + CNT_W'(1);
  assign expire = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= {1'b0, TC_RESET} + CNT_W'(1);
      gen_clk_o <= 1'b0;
      rise_o    <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= reload;
      gen_clk_o <= 1'b0;
      rise_o    <= 1'b0;
    end else if (expire) begin
      cnt_q     <= reload;
      gen_clk_o <= ~gen_clk_o;
      rise_o    <= ~gen_clk_o;
    end else begin
      cnt_q     <= cnt_q - CNT_W'(1);
      rise_o    <= 1'b0;
    end
  end

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gen_clk_o);
  p_no_mid_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !expire) |=> $stable(gen_clk_o));
  p_rise_tracks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (gen_clk_o && !$past(gen_clk_o)));
endmodule

// File: rtl/baud_mode_div.sv
module baud_mode_div
  import baud_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      rise_i,
  input  clk_mode_e mode_i,
  output logic      stb_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last;

  assign last = mode_last(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      stb_o <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      stb_o <= 1'b0;
    end else if (rise_i) begin
      // >= keeps a count wrapping after a switch to a smaller mode
      if (div_q >= last) begin
        div_q <= '0;
        stb_o <= 1'b1;
      end else begin
        div_q <= div_q + DIV_W'(1);
        stb_o <= 1'b0;
      end
    end else begin
      stb_o <= 1'b0;
    end
  end

  p_stb_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  p_stb_after_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $past(rise_i));
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_pkg::*;
#(
  parameter int unsigned TC_W     = 16,
  parameter int unsigned BYTE_W   = 8,
  parameter logic [TC_W-1:0] TC_RESET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] tc_lo_i,
  input  logic              tc_lo_we_i,
  input  logic [BYTE_W-1:0] tc_hi_i,
  input  logic              tc_hi_we_i,
  input  logic [1:0]        mode_i,
  output logic              gen_clk_o,
  output logic              bit_stb_o
);
  logic [TC_W-1:0] tc;
  logic            rise;

  baud_tc_reg #(.TC_W(TC_W), .BYTE_W(BYTE_W), .TC_RESET(TC_RESET)) u_tc (
    .clk_i, .rst_ni,
    .lo_i(tc_lo_i), .lo_we_i(tc_lo_we_i),
    .hi_i(tc_hi_i), .hi_we_i(tc_hi_we_i),
    .tc_o(tc)
  );

  baud_half_ctr #(.TC_W(TC_W), .TC_RESET(TC_RESET)) u_ctr (
    .clk_i, .rst_ni, .en_i,
    .tc_i(tc), .gen_clk_o, .rise_o(rise)
  );

  baud_mode_div u_div (
    .clk_i, .rst_ni, .en_i,
    .rise_i(rise), .mode_i(clk_mode_e'(mode_i)), .stb_o(bit_stb_o)
  );

  p_stb_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_stb_o);
endmodule

// File: tb/baud_gen_top_tb.sv
`timescale 1ns/1ps
module baud_gen_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] tc_lo = '0, tc_hi = '0;
  logic       tc_lo_we = 1'b0, tc_hi_we = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       gen_clk, bit_stb;

  int total = 0, bad = 0;
  int m_hi, m_lo, m_gap, m_stbs, m_lag;
  bit m_wide;

  always #10 clk = ~clk;

  baud_gen_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .tc_lo_i(tc_lo), .tc_lo_we_i(tc_lo_we),
    .tc_hi_i(tc_hi), .tc_hi_we_i(tc_hi_we),
    .mode_i(mode), .gen_clk_o(gen_clk), .bit_stb_o(bit_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tc(input logic [15:0] v);
    @(negedge clk); tc_lo = v[7:0]; tc_lo_we = 1'b1;
    @(negedge clk); tc_lo_we = 1'b0; tc_hi = v[15:8]; tc_hi_we = 1'b1;
    @(negedge clk); tc_hi_we = 1'b0;
  endtask

  task automatic observe(input int n);
    bit pg, ps;
    int run, cyc, rise_at, last_stb;
    pg = gen_clk; ps = 1'b0; run = 0; cyc = 0; rise_at = 0; last_stb = 0;
    m_hi = 0; m_lo = 0; m_gap = 0; m_stbs = 0; m_lag = -1; m_wide = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc++;
      if (gen_clk == pg) run++;
      else begin
        if (pg) m_hi = run; else m_lo = run;
        run = 1;
      end
      if (gen_clk && !pg) rise_at = cyc;
      if (bit_stb) begin
        if (ps) m_wide = 1'b1;
        if (last_stb > 0) m_gap = cyc - last_stb;
        last_stb = cyc; m_stbs++; m_lag = cyc - rise_at;
      end
      pg = gen_clk; ps = bit_stb;
    end
  endtask

  // counts edges from enable until gen_clk rises
  task automatic first_rise(output int lat);
    @(negedge clk); en = 1'b1; lat = 0;
    do begin @(negedge clk); lat++; end while (!gen_clk && lat < 5000);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 gen low in reset", gen_clk, 0);
    chk("R1 stb low in reset", bit_stb, 0);
  endtask

  task automatic t_reset_release;
    int lat;
    en = 1'b1; lat = 0;
    @(negedge clk); rst_n = 1'b1;
    do begin @(negedge clk); lat++; end while (!gen_clk && lat < 100);
    chk("R1 first rise after reset", lat, 2);
  endtask

  task automatic t_x1_period;
    en = 1'b0; mode = 2'b00; set_tc(16'd3);
    en = 1'b1; observe(60);
    chk("R2 high phase TC=3", m_hi, 5);
    chk("R2 low phase TC=3", m_lo, 5);
    chk("R6 x1 strobe gap", m_gap, 10);
    chk("R7 strobe lag", m_lag, 1);
    chk("R7 strobe width", m_wide, 0);
  endtask

  task automatic t_latency;
    int lat;
    en = 1'b0; set_tc(16'd9);
    first_rise(lat);
    chk("R2 first rise latency TC=9", lat, 11);
  endtask

  task automatic t_high_byte;
    en = 1'b0; mode = 2'b00; set_tc(16'h0102);
    en = 1'b1; observe(1700);
    chk("R3 high phase TC=0x0102", m_hi, 260);
    chk("R3 low phase TC=0x0102", m_lo, 260);
  endtask

  task automatic t_mid_write;
    int h, l, h2;
    en = 1'b0; set_tc(16'd20); en = 1'b1;
    do @(negedge clk); while (!gen_clk);
    do @(negedge clk); while (gen_clk);
    do @(negedge clk); while (!gen_clk);
    tc_lo = 8'd5; tc_lo_we = 1'b1; h = 1;
    @(negedge clk); tc_lo_we = 1'b0;
    while (gen_clk) begin h++; @(negedge clk); end
    l = 0; while (!gen_clk) begin l++; @(negedge clk); end
    h2 = 0; while (gen_clk) begin h2++; @(negedge clk); end
    chk("R4 phase in progress keeps old TC", h, 22);
    chk("R4 next low phase new TC", l, 7);
    chk("R4 next high phase new TC", h2, 7);
  endtask

  task automatic t_disabled;
    int seen_g, seen_s;
    en = 1'b0; mode = 2'b00; set_tc(16'd0);
    seen_g = 0; seen_s = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      seen_g += gen_clk; seen_s += bit_stb;
    end
    chk("R5 gen held low when disabled", seen_g, 0);
    chk("R5 no strobe when disabled", seen_s, 0);
  endtask

  task automatic t_mode(input logic [1:0] m, input logic [15:0] tc, input int mult);
    en = 1'b0; mode = m; set_tc(tc);
    en = 1'b1; observe(mult * 2 * (tc + 2) * 2 + 20);
    chk($sformatf("R6 mode %0d strobe gap", m), m_gap, mult * 2 * (tc + 2));
    chk($sformatf("R7 mode %0d strobe width", m), m_wide, 0);
  endtask

  task automatic t_div_clear;
    int lat;
    en = 1'b1; mode = 2'b01; set_tc(16'd0);
    repeat (40) @(negedge clk);
    en = 1'b0; repeat (3) @(negedge clk);
    en = 1'b1; lat = 0;
    do begin @(negedge clk); lat++; end while (!bit_stb && lat < 500);
    chk("R5 divider cleared, first x16 strobe", lat, 63);
  endtask

  initial begin
    t_reset();
    t_reset_release();
    t_x1_period();
    t_latency();
    t_high_byte();
    t_mid_write();
    t_disabled();
    t_mode(2'b01, 16'd0, 16);
    t_mode(2'b10, 16'd1, 32);
    t_mode(2'b11, 16'd0, 64);
    t_div_clear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule